// File: doc/BRIEF.md
# Stride-Filtered Markov Address Predictor

This block supplies the next prefetch address for a stream buffer slot. It learns from retired loads: each training beat carries the load's program counter and data address. A small table indexed by the program counter keeps, per load, the last address it touched, the last delta it saw, a learned stride and a 2-bit confidence count. Whenever a load moves from one address to the next, the move is offered to a first-order Markov table. That table holds one successor per line-granular source address, kept as a signed 16-bit difference and tagged with a few upper address bits.

Moves that match the load's learned stride are not stored, because the stride path already predicts them. Moves whose difference does not fit in 16 signed bits are not stored either. This leaves the Markov storage for irregular, pointer-like transitions.

A stream buffer asks for its next address by presenting its last address and its own stride on the query port. Two cycles later the block returns a registered prediction. On a Markov tag hit, the prediction is the last address plus the stored difference. On a miss, it is the last address plus the supplied stride.

Top module: `sfm_predictor`

## Requirements
- R1: While reset is high and in the first cycle after it, pred_valid is low. After reset no Markov entry is valid, so every query returns last address plus supplied stride.
- R2: pred_valid is high exactly two rising edges after an edge that sampled query_valid high, and low otherwise.
- R3: On a Markov miss, pred_addr equals query_last plus query_stride, modulo 2^ADDR_W.
- R4: On a Markov hit, pred_addr equals query_last plus the sign-extended stored 16-bit difference. Negative differences are included.
- R5: A transition whose delta equals the training PC's learned stride is not written, provided its confidence count is nonzero. A stride is learned once the same delta has been seen twice in a row.
- R6: A single new delta does not replace the learned stride. The transition that first repeats a delta is still filtered against the old stride, and is therefore recorded.
- R7: A transition whose delta lies outside -32768..32767 is not recorded.
- R8: Training state is kept per PC, selected by PC bits [2 +: ST_IDX_W]. A transition is formed only from the same PC's previous address, and a PC's first beat records nothing.
- R9: The Markov table is indexed by address bits [LINE_W +: MK_IDX_W] and tagged with the next TAG_W bits. A query whose tag differs from the stored one is a miss.
- R10: Each Markov slot holds one successor, and a later transition from the same slot replaces the earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| train_valid | input | 1 | training beat present |
| train_pc | input | PC_W | program counter of the retired load |
| train_addr | input | ADDR_W | data address of the retired load |
| query_valid | input | 1 | prediction request |
| query_last | input | ADDR_W | buffer's last address |
| query_stride | input | ADDR_W | buffer's stride, two's complement |
| pred_valid | output | 1 | prediction ready |
| pred_addr | output | ADDR_W | predicted address |

## Verification
The hardest situation to reach is the filter decision, which depends on stride state that no port shows. It has to be inferred from which transitions later turn up as Markov hits. The bench drives one PC through a regular address run. It then queries the source lines of the second, third and fourth beats with a distinct stride. This tells apart the move recorded before the stride was learned from the move suppressed after it. Tag aliasing and overwrite are reached by choosing addresses that share an index but differ in tag, or that revisit a source line.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int SFM_ADDR_W  = 32;
  localparam int SFM_PC_W    = 32;
  localparam int SFM_DELTA_W = 16;

  typedef enum logic {SRC_STRIDE = 1'b0, SRC_MARKOV = 1'b1} pred_src_e;
endpackage

// File: rtl/sfm_stride_table.sv
module sfm_stride_table #(
  parameter int ADDR_W  = 32,
  parameter int PC_W    = 32,
  parameter int IDX_W   = 4,
  parameter int DELTA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_valid,
  input  logic [PC_W-1:0]   train_pc,
  input  logic [ADDR_W-1:0] train_addr,
  output logic              mk_we,
  output logic [ADDR_W-1:0] mk_src_addr,
  output logic [DELTA_W-1:0] mk_delta
);
  localparam int N = 1 << IDX_W;

  logic              vld_q   [N];
  logic [ADDR_W-1:0] last_q  [N];
  logic [ADDR_W-1:0] ldelta_q[N];
  logic [ADDR_W-1:0] stride_q[N];
  logic [1:0]        conf_q  [N];

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] new_delta, cur_stride;
  logic              fits, repeat_hit, stride_eq;

  always_comb begin
    idx        = train_pc[2 +: IDX_W];
    cur_stride = stride_q[idx];
    new_delta  = train_addr - last_q[idx];
    fits       = (&new_delta[ADDR_W-1:DELTA_W-1]) | ~(|new_delta[ADDR_W-1:DELTA_W-1]);
    repeat_hit = (new_delta == ldelta_q[idx]);
    stride_eq  = (conf_q[idx] != 2'd0) && (new_delta == cur_stride);
    mk_we       = train_valid && vld_q[idx] && !stride_eq && fits;
    mk_src_addr = last_q[idx];
    mk_delta    = new_delta[DELTA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        vld_q[i]  <= 1'b0;
        conf_q[i] <= 2'd0;
      end
    end else if (train_valid) begin
      vld_q[idx]  <= 1'b1;
      last_q[idx] <= train_addr;
      if (!vld_q[idx]) begin
        ldelta_q[idx] <= '0;
        stride_q[idx] <= '0;
        conf_q[idx]   <= 2'd0;
      end else begin
        ldelta_q[idx] <= new_delta;
        if (repeat_hit) begin
          stride_q[idx] <= new_delta;
          conf_q[idx]   <= (conf_q[idx] == 2'd3) ? 2'd3 : conf_q[idx] + 2'd1;
        end else begin
          conf_q[idx]   <= (conf_q[idx] == 2'd0) ? 2'd0 : conf_q[idx] - 2'd1;
        end
      end
    end
  end

  // Assertion support: remember which entry was touched last cycle.
  logic [IDX_W-1:0] idx_d;
  logic             hold_chk;
  always_ff @(posedge clk) idx_d <= idx;
  assign hold_chk = train_valid && vld_q[idx] && !repeat_hit;

  // A delta not seen twice in a row must leave the learned stride alone.
  assert_stride_hold_R6: assert property (@(posedge clk) disable iff (rst)
    hold_chk |=> (stride_q[idx_d] == $past(cur_stride)));
endmodule

// File: rtl/sfm_markov_table.sv
module sfm_markov_table #(
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 6,
  parameter int IDX_W   = 11,
  parameter int TAG_W   = 8,
  parameter int DELTA_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DELTA_W-1:0] wr_delta,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic               rd_hit,
  output logic [DELTA_W-1:0] rd_delta
);
  localparam int N      = 1 << IDX_W;
  localparam int WORD_W = TAG_W + DELTA_W;

  logic [WORD_W-1:0] mem [N];
  logic [N-1:0]      vld_q;
  logic [WORD_W-1:0] rd_word_q;
  logic              rd_vld_q;
  logic [TAG_W-1:0]  rd_tag_q;

  logic [IDX_W-1:0] widx, ridx;
  logic [TAG_W-1:0] wtag, rtag;
  assign widx = wr_addr[LINE_W +: IDX_W];
  assign wtag = wr_addr[LINE_W+IDX_W +: TAG_W];
  assign ridx = rd_addr[LINE_W +: IDX_W];
  assign rtag = rd_addr[LINE_W+IDX_W +: TAG_W];

  // Plain RAM process: one write port, one registered read port, no reset.
  always_ff @(posedge clk) begin
    if (wr_en) mem[widx] <= {wtag, wr_delta};
    if (rd_en) rd_word_q <= mem[ridx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      rd_vld_q <= 1'b0;
      rd_tag_q <= '0;
    end else begin
      if (wr_en) vld_q[widx] <= 1'b1;
      if (rd_en) begin
        rd_vld_q <= vld_q[ridx];
        rd_tag_q <= rtag;
      end
    end
  end

  assign rd_hit   = rd_vld_q && (rd_word_q[DELTA_W +: TAG_W] == rd_tag_q);
  assign rd_delta = rd_word_q[DELTA_W-1:0];

  // A written slot must read back as valid from the next cycle on.
  logic [IDX_W-1:0] widx_d;
  always_ff @(posedge clk) widx_d <= widx;
  assert_slot_valid_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> vld_q[widx_d]);
endmodule

// File: rtl/sfm_predictor.sv
module sfm_predictor
  import sfm_pkg::*;
#(
  parameter int ADDR_W   = SFM_ADDR_W,
  parameter int PC_W     = SFM_PC_W,
  parameter int DELTA_W  = SFM_DELTA_W,
  parameter int LINE_W   = 6,
  parameter int MK_IDX_W = 11,
  parameter int TAG_W    = 8,
  parameter int ST_IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              train_valid,
  input  logic [PC_W-1:0]   train_pc,
  input  logic [ADDR_W-1:0] train_addr,
  input  logic              query_valid,
  input  logic [ADDR_W-1:0] query_last,
  input  logic [ADDR_W-1:0] query_stride,
  output logic              pred_valid,
  output logic [ADDR_W-1:0] pred_addr
);
  localparam int EXT_W = ADDR_W - DELTA_W;

  logic               mk_we;
  logic [ADDR_W-1:0]  mk_src_addr;
  logic [DELTA_W-1:0] mk_delta;
  logic               rd_hit;
  logic [DELTA_W-1:0] rd_delta;

  sfm_stride_table #(
    .ADDR_W(ADDR_W), .PC_W(PC_W), .IDX_W(ST_IDX_W), .DELTA_W(DELTA_W)
  ) u_stride (
    .clk(clk), .rst(rst),
    .train_valid(train_valid), .train_pc(train_pc), .train_addr(train_addr),
    .mk_we(mk_we), .mk_src_addr(mk_src_addr), .mk_delta(mk_delta)
  );

  sfm_markov_table #(
    .ADDR_W(ADDR_W), .LINE_W(LINE_W), .IDX_W(MK_IDX_W),
    .TAG_W(TAG_W), .DELTA_W(DELTA_W)
  ) u_markov (
    .clk(clk), .rst(rst),
    .wr_en(mk_we), .wr_addr(mk_src_addr), .wr_delta(mk_delta),
    .rd_en(query_valid), .rd_addr(query_last),
    .rd_hit(rd_hit), .rd_delta(rd_delta)
  );

  // Stage 1 carries the query alongside the table read.
  logic              s1_valid;
  logic [ADDR_W-1:0] s1_last, s1_stride;
  pred_src_e         src;
  logic [ADDR_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
    end else begin
      s1_valid <= query_valid;
    end
    if (query_valid) begin
      s1_last   <= query_last;
      s1_stride <= query_stride;
    end
  end

  always_comb begin
    src  = rd_hit ? SRC_MARKOV : SRC_STRIDE;
    step = (src == SRC_MARKOV) ? {{EXT_W{rd_delta[DELTA_W-1]}}, rd_delta} : s1_stride;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_addr  <= '0;
    end else begin
      pred_valid <= s1_valid;
      if (s1_valid) pred_addr <= s1_last + step;
    end
  end

  assert_idle_after_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> !pred_valid);

  assert_two_cycle_latency_R2: assert property (@(posedge clk) disable iff (rst)
    query_valid |-> ##2 pred_valid);

  assert_no_spurious_valid_R2: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(query_valid, 2));
endmodule

// File: tb/tb_sfm_predictor.sv
`timescale 1ns/1ps
module tb_sfm_predictor;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          train_valid;
  logic [31:0]   train_pc;
  logic [AW-1:0] train_addr;
  logic          query_valid;
  logic [AW-1:0] query_last, query_stride;
  logic          pred_valid;
  logic [AW-1:0] pred_addr;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sfm_predictor #(.MK_IDX_W(6)) dut (
    .clk(clk), .rst(rst),
    .train_valid(train_valid), .train_pc(train_pc), .train_addr(train_addr),
    .query_valid(query_valid), .query_last(query_last), .query_stride(query_stride),
    .pred_valid(pred_valid), .pred_addr(pred_addr)
  );

  task automatic check(input logic ok, input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic train(input logic [31:0] pc, input logic [AW-1:0] a);
    @(negedge clk);
    train_valid = 1'b1; train_pc = pc; train_addr = a;
    @(negedge clk);
    train_valid = 1'b0;
  endtask

  // Query, then check the two-cycle timing (R2) and the returned address.
  task automatic query(input logic [AW-1:0] last, input logic [AW-1:0] stride,
                       input logic [AW-1:0] exp, input string req);
    @(negedge clk);
    query_valid = 1'b1; query_last = last; query_stride = stride;
    @(negedge clk);
    query_valid = 1'b0;
    check(pred_valid == 1'b0, "R2 early", {31'd0, pred_valid}, 0);
    @(negedge clk);
    check(pred_valid == 1'b1, "R2 valid", {31'd0, pred_valid}, 1);
    check(pred_addr == exp, req, pred_addr, exp);
    @(negedge clk);
    check(pred_valid == 1'b0, "R2 drop", {31'd0, pred_valid}, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(pred_valid == 1'b0, "R1 reset", {31'd0, pred_valid}, 0);
    query(32'h0000_1000, 32'h40, 32'h0000_1040, "R1 empty table");
    query(32'hFFFF_FFF0, 32'h20, 32'h0000_0010, "R3 wrap");
  endtask

  task automatic t_stride_filter;
    logic [AW-1:0] a = 32'h0001_0000;
    train(32'h104, a);
    train(32'h104, a + 64);
    train(32'h104, a + 128);
    train(32'h104, a + 192);
    query(a + 128, 32'd4, a + 132, "R5 strided move filtered");
    query(a + 64,  32'd4, a + 128, "R6 repeat move recorded");
    query(a,       32'd4, a + 64,  "R4 hit");
    query(a + 32'h1000, 32'd8, a + 32'h1008, "R9 tag mismatch");
  endtask

  task automatic t_range;
    logic [AW-1:0] c = 32'h0002_0400;
    train(32'h208, c);
    train(32'h208, c + 32'h2_0000);
    query(c, 32'd12, c + 12, "R7 wide delta dropped");
  endtask

  task automatic t_per_pc;
    logic [AW-1:0] x = 32'h0003_0800;
    logic [AW-1:0] y = 32'h0004_0A00;
    train(32'h30C, x);
    train(32'h310, y);
    train(32'h30C, x + 256);
    query(x, 32'd4,  x + 256, "R8 same-pc move");
    query(y, 32'd16, y + 16,  "R8 first beat no record");
  endtask

  task automatic t_overwrite;
    logic [AW-1:0] d = 32'h0005_0C00;
    train(32'h414, d);
    train(32'h414, d + 512);
    train(32'h414, d);
    train(32'h414, d + 1024);
    query(d,       32'd4, d + 1024, "R10 replaced successor");
    query(d + 512, 32'd4, d,        "R4 negative delta");
    query(d + 1024, 32'hFFFF_FFC0, d + 1024 - 64, "R3 negative stride");
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; train_valid = 1'b0; train_pc = '0; train_addr = '0;
    query_valid = 1'b0; query_last = '0; query_stride = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(pred_valid == 1'b0, "R1 in reset", {31'd0, pred_valid}, 0);
    rst = 1'b0;
    t_reset();
    t_stride_filter();
    t_range();
    t_per_pc();
    t_overwrite();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule